// File: doc/BRIEF.md
# PCI Posted Memory Write Target

This block is the target-side front end of one port of a PCI-to-PCI bridge. It watches the initiator bus for write transactions. It claims the memory writes that should be posted across the bridge and stores their address and data in a local queue, so the initiator never waits for the far bus. A drain port on the far side takes queue entries out in order.

A claim is made with medium decode timing, and the target then accepts one DWORD per clock with no wait states. The burst runs until the initiator ends it, or until the target cuts it with a disconnect. The target disconnects when the next word would cross the address boundary that belongs to the command, or when the queue is about to fill. I/O writes, Type 1 configuration writes and memory writes into the legacy video range must go through the bridge as delayed writes. For these the block raises a one-clock flag and leaves the bus alone.

Top module: `pmw_target`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle and clears the queue. After that edge `devsel_n`, `trdy_n` and `stop_n` are high, `delayed_o` is low and `q_valid` is low.
- R2: An address phase is a clock in which `frame_n` is sampled low after a clock with both `frame_n` and `irdy_n` high. A posted write is claimed when the command on `cbe_n` is 4'b0111 (memory write) or 4'b1111 (memory write and invalidate), the address lies in `win_base`..`win_limit` inclusive, and the address is outside 0x000A0000..0x000BFFFF. On a claim, `devsel_n` goes low in the second clock after the address phase and `trdy_n` goes low one clock later. An address entry (tag 0, last 0, payload = address) is queued at the address phase.
- R3: A posted write is not claimed when the queue holds more than DEPTH-2 entries at the address phase. In that case `devsel_n`, `trdy_n` and `stop_n` stay high and nothing is queued.
- R4: A data word is taken only at an edge where `irdy_n` and `trdy_n` are both low. Each such edge queues one data entry (tag 1, payload = `ad`). Once asserted, `trdy_n` stays low through initiator wait states, so the target inserts no wait states.
- R5: A transfer with `frame_n` high is the final one. Its entry has the last flag set, and `devsel_n`, `trdy_n` and `stop_n` are all high in the next clock.
- R6: For command 4'b1111, `stop_n` is low together with `trdy_n` on the data phase whose DWORD address (`address[31:2]`) has all bits under the mask `cfg_cls`-1 set. `cfg_cls` is the cache line length in DWORDs and is a power of two. The DWORD address steps by one per word.
- R7: For command 4'b0111, `stop_n` is low together with `trdy_n` on the data phase whose byte address has bits [11:2] all ones, which is the last word of an aligned 4KB page.
- R8: `stop_n` is low together with `trdy_n` on the data phase whose word fills the last free queue slot.
- R9: A word taken while `stop_n` is low is the final one and has the last flag set. If `frame_n` is still low at that edge, the next clock has `trdy_n` high with `stop_n` and `devsel_n` still low. All three are released after the edge at which `frame_n` is sampled high.
- R10: At an address phase, the following raise `delayed_o` for exactly one clock, starting the clock after the address phase, and are not claimed: command 4'b0011 (I/O write) inside the window, command 4'b1011 with `ad[1:0]` = 2'b01 (Type 1 configuration write), and command 4'b0111 or 4'b1111 addressed inside 0x000A0000..0x000BFFFF.
- R11: Other commands, and memory writes outside the window, are neither claimed nor flagged and queue nothing.
- R12: The queue gives entries to the drain port in the order they were written. `q_valid` shows that the head is present, and a clock with `q_rd_en` high removes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cls | input | 8 | Cache line length in DWORDs (power of two) |
| win_base | input | 32 | Lowest byte address forwarded |
| win_limit | input | 32 | Highest byte address forwarded |
| frame_n | input | 1 | Initiator cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command in address phase, byte enables in data phases |
| ad | input | 32 | Multiplexed address and data |
| devsel_n | output | 1 | Target claim, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop (disconnect), active low |
| delayed_o | output | 1 | One-clock flag for a write needing delayed handling |
| q_rd_en | input | 1 | Remove the queue head |
| q_valid | output | 1 | Queue head present |
| q_tag | output | 1 | Head entry kind: 0 address, 1 data |
| q_last | output | 1 | Head entry is the final data word of its burst |
| q_data | output | 32 | Head entry payload |

## Verification
The assertions assume an initiator that follows the bus rules. It holds `frame_n` low during a burst until its final phase. It releases `frame_n` once it sees a disconnect. It never starts a new address phase without an idle clock. It keeps `cfg_cls` a stable power of two for the length of a burst. The directed stimulus does all of this by construction. Each burst ends either with `frame_n` raised alongside the final word or with `frame_n` released in the clock after a disconnect, always followed by an idle clock. The drain port stays idle during bursts, so the disconnect point the bench computes from its own queue count matches the design exactly.

// File: rtl/pmw_pkg.sv
// Package: shared widths, command codes and queue entry layout for the
// posted memory write target. Assumes a 32-bit address/data bus.
package pmw_pkg;

    localparam int AD_W = 32;
    localparam int DW_W = AD_W - 2;

    localparam logic [3:0] CMD_IO_WR   = 4'b0011;
    localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
    localparam logic [3:0] CMD_CFG_WR  = 4'b1011;
    localparam logic [3:0] CMD_MEM_WRI = 4'b1111;

    // Legacy video range: bits [31:17] equal to this value.
    localparam logic [14:0] VGA_HI = 15'h0005;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEC,
        ST_TGT,
        ST_XFER,
        ST_DISC
    } tgt_state_t;

    typedef struct packed {
        logic            tag;      // 0 address, 1 data
        logic            last;     // final data word of the burst
        logic [AD_W-1:0] payload;
    } q_entry_t;

endpackage

// File: rtl/pmw_fifo.sv
// Module: synchronous show-ahead FIFO for queue entries.
// Assumes: single clock; push while full and pop while empty are dropped;
// count reports occupancy in the same cycle as the flags.
module pmw_fifo #(
    parameter int WIDTH = 34,
    parameter int DEPTH = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [WIDTH-1:0]               wdata,
    input  logic                           pop,
    output logic [WIDTH-1:0]               rdata,
    output logic                           empty,
    output logic                           full,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             push_ok;
    logic             pop_ok;

    // Status and gated strobes.
    always_comb begin
        empty   = (cnt_q == '0);
        full    = (cnt_q == CNT_FULL);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        count   = cnt_q;
        rdata   = mem[rd_ptr];
    end

    // Storage write port.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PTR_W'(1);
            end
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R8

endmodule

// File: rtl/pmw_decode.sv
// Module: address-phase classifier. Splits a write command into posted,
// delayed or ignored. Assumes the window bounds are inclusive and stable.
module pmw_decode
    import pmw_pkg::*;
#(
    parameter int A_W = AD_W
) (
    input  logic [3:0]     cmd,
    input  logic [A_W-1:0] addr,
    input  logic [A_W-1:0] win_base,
    input  logic [A_W-1:0] win_limit,
    output logic           posted_hit,
    output logic           delayed_hit
);
    logic in_win;
    logic in_vga;
    logic is_mem_wr;

    // Command and range classification.
    always_comb begin
        in_win      = (addr >= win_base) && (addr <= win_limit);
        in_vga      = (addr[A_W-1:17] == (A_W-17)'(VGA_HI));
        is_mem_wr   = (cmd == CMD_MEM_WR) || (cmd == CMD_MEM_WRI);
        posted_hit  = is_mem_wr && in_win && !in_vga;
        delayed_hit = (is_mem_wr && in_vga)
                   || ((cmd == CMD_IO_WR) && in_win)
                   || ((cmd == CMD_CFG_WR) && (addr[1:0] == 2'b01));
    end

endmodule

// File: rtl/pmw_bound.sv
// Module: decides whether a DWORD address is the last one before the
// disconnect boundary of the current command. Assumes cls_dw is a
// nonzero power of two no wider than CLS_W bits.
module pmw_bound #(
    parameter int DW_W      = 30,
    parameter int CLS_W     = 8,
    parameter int PAGE_BITS = 10
) (
    input  logic [DW_W-1:0]  dw_addr,
    input  logic [CLS_W-1:0] cls_dw,
    input  logic             line_mode,
    output logic             at_edge
);
    logic [CLS_W-1:0] mask;
    logic             line_end;
    logic             page_end;

    // Line end from the cache-line mask, page end from the low DWORD bits.
    always_comb begin
        mask     = cls_dw - CLS_W'(1);
        line_end = ((dw_addr[CLS_W-1:0] & mask) == mask);
        page_end = &dw_addr[PAGE_BITS-1:0];
        at_edge  = line_mode ? line_end : page_end;
    end

endmodule

// File: rtl/pmw_target.sv
// Module: posted memory write target. Claims memory writes with medium
// decode timing, takes one DWORD per clock and disconnects at the
// command's address boundary or when the queue would fill.
// Assumes: initiator obeys bus rules; drain side may pop at any time.
module pmw_target
    import pmw_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int CLS_W     = 8,
    parameter int PAGE_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CLS_W-1:0]  cfg_cls,
    input  logic [AD_W-1:0]   win_base,
    input  logic [AD_W-1:0]   win_limit,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic [3:0]        cbe_n,
    input  logic [AD_W-1:0]   ad,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              stop_n,
    output logic              delayed_o,
    input  logic              q_rd_en,
    output logic              q_valid,
    output logic              q_tag,
    output logic              q_last,
    output logic [AD_W-1:0]   q_data
);
    localparam int ENT_W = $bits(q_entry_t);
    localparam int CNT_W = $clog2(DEPTH + 1);

    tgt_state_t       state;
    logic             devsel_q, trdy_q, stop_q, delayed_q;
    logic             prev_frame_n, prev_irdy_n;
    logic [DW_W-1:0]  addr_q;
    logic             mwi_q;

    logic             addr_phase, posted_hit, delayed_hit, room;
    logic             xfer, final_xfer, push_addr, push_data;
    logic [DW_W-1:0]  probe_addr;
    logic             probe_line, probe_edge, fill_next, stop_nx;
    logic             fifo_push, fifo_empty, fifo_full;
    logic [CNT_W-1:0] fifo_cnt;
    q_entry_t         wr_ent, rd_ent;

    pmw_decode #(.A_W(AD_W)) dec_i (
        .cmd         (cbe_n),
        .addr        (ad),
        .win_base    (win_base),
        .win_limit   (win_limit),
        .posted_hit  (posted_hit),
        .delayed_hit (delayed_hit)
    );

    pmw_bound #(.DW_W(DW_W), .CLS_W(CLS_W), .PAGE_BITS(PAGE_BITS)) bnd_i (
        .dw_addr   (probe_addr),
        .cls_dw    (cfg_cls),
        .line_mode (probe_line),
        .at_edge   (probe_edge)
    );

    // Bus phase detection and claim/transfer strobes.
    always_comb begin
        addr_phase = !frame_n && prev_frame_n && prev_irdy_n && (state == ST_IDLE);
        room       = (int'(fifo_cnt) <= DEPTH - 2);
        push_addr  = addr_phase && posted_hit && room;
        xfer       = (state == ST_XFER) && !irdy_n;
        final_xfer = xfer && (frame_n || stop_q);
        push_data  = xfer;
    end

    // Predict the disconnect for the data phase that follows.
    always_comb begin
        if (state == ST_XFER) begin
            probe_addr = addr_q + DW_W'(1);
            fill_next  = (int'(fifo_cnt) + 2 >= DEPTH);
        end else begin
            probe_addr = addr_q;
            fill_next  = (int'(fifo_cnt) + 1 >= DEPTH);
        end
        probe_line = mwi_q;
        stop_nx    = probe_edge || fill_next;
    end

    // Queue write entry mux.
    always_comb begin
        fifo_push = push_addr || push_data;
        if (push_addr) begin
            wr_ent = '{tag: 1'b0, last: 1'b0, payload: ad};
        end else begin
            wr_ent = '{tag: 1'b1, last: final_xfer, payload: ad};
        end
    end

    pmw_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .wdata (wr_ent),
        .pop   (q_rd_en),
        .rdata (rd_ent),
        .empty (fifo_empty),
        .full  (fifo_full),
        .count (fifo_cnt)
    );

    // Target state machine and registered bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            devsel_q     <= 1'b0;
            trdy_q       <= 1'b0;
            stop_q       <= 1'b0;
            delayed_q    <= 1'b0;
            prev_frame_n <= 1'b1;
            prev_irdy_n  <= 1'b1;
            addr_q       <= '0;
            mwi_q        <= 1'b0;
        end else begin
            prev_frame_n <= frame_n;
            prev_irdy_n  <= irdy_n;
            delayed_q    <= addr_phase && delayed_hit;
            case (state)
                ST_IDLE: begin
                    if (push_addr) begin
                        addr_q <= ad[AD_W-1:2];
                        mwi_q  <= (cbe_n == CMD_MEM_WRI);
                        state  <= ST_DEC;
                    end
                end
                ST_DEC: begin
                    devsel_q <= 1'b1;
                    state    <= ST_TGT;
                end
                ST_TGT: begin
                    trdy_q <= 1'b1;
                    stop_q <= stop_nx;
                    state  <= ST_XFER;
                end
                ST_XFER: begin
                    if (final_xfer) begin
                        trdy_q <= 1'b0;
                        if (stop_q && !frame_n) begin
                            state <= ST_DISC;
                        end else begin
                            devsel_q <= 1'b0;
                            stop_q   <= 1'b0;
                            state    <= ST_IDLE;
                        end
                    end else if (xfer) begin
                        addr_q <= addr_q + DW_W'(1);
                        stop_q <= stop_nx;
                    end
                end
                ST_DISC: begin
                    if (frame_n) begin
                        devsel_q <= 1'b0;
                        stop_q   <= 1'b0;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Active-low pins and drain-side view.
    always_comb begin
        devsel_n  = !devsel_q;
        trdy_n    = !trdy_q;
        stop_n    = !stop_q;
        delayed_o = delayed_q;
        q_valid   = !fifo_empty;
        q_tag     = rd_ent.tag;
        q_last    = rd_ent.last;
        q_data    = rd_ent.payload;
    end

    AST_TRDY_NEEDS_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n); // R2
    AST_MEDIUM_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> !$past(frame_n, 2)); // R2
    AST_TRDY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |=> $fell(trdy_n)); // R2
    AST_PUSH_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        push_data |-> (!irdy_n && !trdy_n)); // R4
    AST_STOP_NEEDS_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n |-> !devsel_n); // R9
    AST_DISC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && trdy_n && !frame_n) |=> !stop_n); // R9
    AST_DELAYED_UNCLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
        delayed_o |-> devsel_n); // R10

endmodule

// File: tb/pmw_target_tb_top.sv
// Directed bench for the posted memory write target.
`timescale 1ns/1ps
module pmw_target_tb_top;

    localparam int DEPTH = 8;
    localparam logic [3:0] MW  = 4'b0111;
    localparam logic [3:0] MWI = 4'b1111;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  cfg_cls;
    logic [31:0] win_base, win_limit;
    logic        frame_n, irdy_n;
    logic [3:0]  cbe_n;
    logic [31:0] ad;
    logic        devsel_n, trdy_n, stop_n, delayed_o;
    logic        q_rd_en, q_valid, q_tag, q_last;
    logic [31:0] q_data;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic [33:0] exp_q [64];
    int          exp_wr = 0;
    int          exp_rd = 0;

    always #10 clk = ~clk;

    pmw_target #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_cls(cfg_cls),
        .win_base(win_base), .win_limit(win_limit),
        .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n), .ad(ad),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
        .delayed_o(delayed_o), .q_rd_en(q_rd_en), .q_valid(q_valid),
        .q_tag(q_tag), .q_last(q_last), .q_data(q_data)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [33:0] act, input logic [33:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] dat(input logic [31:0] base, input int k);
        return base ^ (32'hA5A5_0000 + 32'(k));
    endfunction

    task automatic exp_push(input logic tag, input logic last, input logic [31:0] v);
        exp_q[exp_wr] = {tag, last, v};
        exp_wr = exp_wr + 1;
    endtask

    // Burst of n words; wait_k inserts one initiator wait state before word wait_k.
    task automatic burst(input logic [31:0] base, input logic [3:0] cmd, input int n,
                         input int wait_k, input string rq);
        int  k = 0;
        bit  stalled = 0;
        bit  done = 0;
        bit  disc = 0;
        bit  pstop;
        logic [31:0] a;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad = base; cbe_n = cmd;
        @(negedge clk);
        chk(devsel_n == 1'b1, "R2", "devsel one clock after address", 34'(devsel_n), 34'd1);
        exp_push(1'b0, 1'b0, base);
        frame_n = (n == 1); irdy_n = 1'b0; ad = dat(base, 0); cbe_n = 4'h0;
        @(negedge clk);
        chk(devsel_n == 1'b0 && trdy_n == 1'b1, "R2", "medium devsel, trdy pending",
            {32'd0, devsel_n, trdy_n}, 34'b01);
        @(negedge clk);
        while (!done) begin
            if (k == wait_k && !stalled) begin
                irdy_n = 1'b1; stalled = 1;
                chk(trdy_n == 1'b0, "R4", "trdy held during initiator wait", 34'(trdy_n), 34'd0);
            end else begin
                irdy_n = 1'b0;
            end
            ad = dat(base, k);
            frame_n = (k == n - 1);
            if (trdy_n != 1'b0) begin
                chk(1'b0, rq, "trdy deasserted mid burst", 34'(trdy_n), 34'd0);
                done = 1;
            end else if (irdy_n == 1'b0) begin
                a = base + 32'(4 * k);
                if (cmd == MWI)
                    pstop = (((a >> 2) & 32'(cfg_cls - 8'd1)) == 32'(cfg_cls - 8'd1));
                else
                    pstop = (a[11:2] == 10'h3FF);
                if ((exp_wr - exp_rd) + 1 == DEPTH) pstop = 1;
                chk(stop_n == !pstop, rq, $sformatf("stop on word %0d", k),
                    34'(stop_n), 34'(!pstop));
                exp_push(1'b1, (k == n - 1) || pstop, dat(base, k));
                if (pstop && k != n - 1) disc = 1;
                done = (k == n - 1) || pstop;
                k = k + 1;
            end
            @(negedge clk);
        end
        if (disc) begin
            chk(trdy_n == 1'b1 && stop_n == 1'b0 && devsel_n == 1'b0, "R9",
                "stop held after disconnect", {31'd0, trdy_n, stop_n, devsel_n}, 34'b100);
            frame_n = 1'b1;
            @(negedge clk);
            chk(stop_n == 1'b1 && devsel_n == 1'b1, "R9", "release after frame high",
                {32'd0, stop_n, devsel_n}, 34'b11);
        end else begin
            chk(devsel_n && trdy_n && stop_n, "R5", "release after final word",
                {31'd0, devsel_n, trdy_n, stop_n}, 34'b111);
        end
        frame_n = 1'b1; irdy_n = 1'b1;
        @(negedge clk);
    endtask

    // Address phase that must not be claimed.
    task automatic probe(input logic [31:0] addr, input logic [3:0] cmd,
                         input logic exp_dly, input string rq);
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad = addr; cbe_n = cmd;
        @(negedge clk);
        chk(delayed_o == exp_dly, rq, "delayed flag", 34'(delayed_o), 34'(exp_dly));
        frame_n = 1'b1; irdy_n = 1'b0; ad = 32'h0; cbe_n = 4'h0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(devsel_n && trdy_n && stop_n, rq, "not claimed",
                {31'd0, devsel_n, trdy_n, stop_n}, 34'b111);
            if (i == 0)
                chk(delayed_o == 1'b0, rq, "delayed flag one clock", 34'(delayed_o), 34'd0);
        end
        irdy_n = 1'b1;
        @(negedge clk);
    endtask

    // Pop every expected entry and compare in order.
    task automatic drain(input string rq);
        while (exp_rd < exp_wr) begin
            chk(q_valid == 1'b1, "R12", "head present", 34'(q_valid), 34'd1);
            chk({q_tag, q_last, q_data} == exp_q[exp_rd], rq,
                $sformatf("entry %0d", exp_rd), {q_tag, q_last, q_data}, exp_q[exp_rd]);
            q_rd_en = 1'b1;
            exp_rd = exp_rd + 1;
            @(negedge clk);
        end
        q_rd_en = 1'b0;
        chk(q_valid == 1'b0, "R12", "queue empty after drain", 34'(q_valid), 34'd0);
        exp_wr = 0; exp_rd = 0;
    endtask

    initial begin
        rst_n = 1'b0; cfg_cls = 8'd4;
        win_base = 32'h0000_0000; win_limit = 32'h1FFF_FFFF;
        frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'h0; ad = 32'h0; q_rd_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(devsel_n && trdy_n && stop_n && !delayed_o && !q_valid, "R1", "reset state",
            {29'd0, devsel_n, trdy_n, stop_n, delayed_o, q_valid}, 34'b11100);
        rst_n = 1'b1;
        @(negedge clk);

        burst(32'h1000_0100, MW, 4, -1, "R2");           // plain burst, initiator end
        drain("R5");
        burst(32'h1000_0200, MW, 3, 1, "R4");            // initiator wait state
        drain("R4");
        burst(32'h1000_0008, MWI, 5, -1, "R6");          // line of 4, cut after 2 words
        drain("R6");
        cfg_cls = 8'd8;
        burst(32'h1000_0010, MWI, 6, -1, "R6");          // line of 8, cut after 4 words
        drain("R6");
        burst(32'h1000_0FF8, MW, 4, -1, "R7");           // 4KB page end
        drain("R7");
        burst(32'h1000_2000, MW, 10, -1, "R8");          // queue fills after 7 words
        probe(32'h1000_3000, MW, 1'b0, "R3");            // no room: not claimed
        drain("R3");

        probe(32'h1000_0000, 4'b0011, 1'b1, "R10");      // I/O write
        probe(32'h0001_0001, 4'b1011, 1'b1, "R10");      // Type 1 configuration write
        probe(32'h000A_0000, MW, 1'b1, "R10");           // video range memory write
        probe(32'h000B_FFFC, MWI, 1'b1, "R10");          // video range, invalidate form
        probe(32'h0001_0000, 4'b1011, 1'b0, "R11");      // Type 0 configuration write
        probe(32'h3000_0000, MW, 1'b0, "R11");           // outside window
        probe(32'h1000_0000, 4'b0110, 1'b0, "R11");      // memory read
        chk(q_valid == 1'b0, "R11", "nothing queued by unclaimed cycles", 34'(q_valid), 34'd0);

        burst(32'h1000_0400, MW, 2, -1, "R2");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(q_valid == 1'b0, "R1", "reset clears queue", 34'(q_valid), 34'd0);
        exp_wr = 0; exp_rd = 0;
        @(negedge clk);

        finish_run();
    end

endmodule